// File: doc/BRIEF.md
# Packed 16-bit Multiply Unit

This unit treats each of its two 64-bit operands as four independent 16-bit lanes and multiplies them lane by lane, giving one 32-bit product per lane. A two-bit mode select chooses which half of each product goes to the 64-bit result. The choices are the low half, the upper half of the signed product, and the upper half of the unsigned product. The low half does not depend on signedness, so there is only one low mode.

The result appears two clock cycles after the operands, with its own valid flag. Stage one registers the four full products. Stage two selects the half for each lane and registers the result. A new operation can be accepted on every cycle. When no new result arrives, the result register keeps its last value.

Top module: `pmul16x4`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 exactly two rising edges after an edge that sampled `op_valid`=1, and 0 otherwise. Operations can be issued on consecutive cycles.
- R3: With mode 0, each result lane holds bits [15:0] of the product of the two operand lanes.
- R4: With mode 1, each result lane holds bits [31:16] of the two's-complement signed product of the operand lanes. For example, 0x8000 times 0x7FFF gives 0xC000, and 0xFFFF times 0xFFFF gives 0x0000.
- R5: With mode 2, each result lane holds bits [31:16] of the unsigned product of the operand lanes. For example, 0xFFFF times 0xFFFF gives 0xFFFE.
- R6: With mode 3, the result is all zeros.
- R7: Lane i uses only operand bits [16i+15:16i] and writes only result bits [16i+15:16i]. No carry or sign passes between lanes.
- R8: When no result is delivered (`res_valid`=0), `res_data` keeps the value of the last delivered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operands and mode are valid this cycle |
| op_mode | input | 2 | 0 low half, 1 signed high half, 2 unsigned high half, 3 zero |
| op_a | input | 64 | First operand, four 16-bit lanes |
| op_b | input | 64 | Second operand, four 16-bit lanes |
| res_valid | output | 1 | Result valid, two cycles after the operands |
| res_data | output | 64 | Selected product halves, four 16-bit lanes |

## Verification
Random operands almost never hit the cases where signed and unsigned upper halves differ at the extremes, such as 0x8000 or 0xFFFF in both lanes. Directed vectors therefore put these values into chosen lanes, next to lanes holding ordinary values, so that any leakage between lanes is visible. A second difficult case is the hold behaviour. Random idle gaps are placed between operations, including straight after a mode-3 zero result. The bench then checks that the last delivered result stays on the output and is not overwritten by the product of a cycle without valid.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    MODE_LOW   = 2'd0,
    MODE_HI_S  = 2'd1,
    MODE_HI_U  = 2'd2,
    MODE_ZERO  = 2'd3
  } pmul_mode_e;

  // Full 32-bit lane product, signed or unsigned interpretation
  function automatic logic [31:0] lane_product(input logic [15:0] a,
                                               input logic [15:0] b,
                                               input logic        uns);
    logic [31:0] ea;
    logic [31:0] eb;
    ea = uns ? {16'd0, a} : {{16{a[15]}}, a};
    eb = uns ? {16'd0, b} : {{16{b[15]}}, b};
    return ea * eb;
  endfunction

  // Half selection for one lane
  function automatic logic [15:0] pick_half(input logic [31:0] p,
                                            input pmul_mode_e  m);
    case (m)
      MODE_LOW:  return p[15:0];
      MODE_HI_S: return p[31:16];
      MODE_HI_U: return p[31:16];
      default:   return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult
  import pmul_pkg::*;
#(
  parameter int LW = 16,
  localparam int PW = 2 * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          uns,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] prod_next;
  assign prod_next = lane_product(a, b, uns);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod <= '0;
    else if (en) prod <= prod_next;
  end
endmodule

// File: rtl/pmul_half_sel.sv
module pmul_half_sel
  import pmul_pkg::*;
#(
  parameter int LW = 16,
  localparam int PW = 2 * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pmul_mode_e    mode,
  input  logic [PW-1:0] prod,
  output logic [LW-1:0] half
);
  logic [LW-1:0] half_next;
  assign half_next = pick_half(prod, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  half <= '0;
    else if (en) half <= half_next;
  end
endmodule

// File: rtl/pmul16x4.sv
module pmul16x4
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int PW   = 2 * LW,
  localparam int DW   = LANES * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_mode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  // Stage one control
  logic       s1_valid;
  pmul_mode_e s1_mode;
  logic       mode_unsigned;

  assign mode_unsigned = (pmul_mode_e'(op_mode) == MODE_HI_U);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_LOW;
    end else begin
      s1_valid <= op_valid;
      if (op_valid) s1_mode <= pmul_mode_e'(op_mode);
    end
  end

  logic [PW-1:0] s1_prod [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul_lane_mult #(.LW(LW)) u_mult (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (op_valid),
      .uns  (mode_unsigned),
      .a    (op_a[i*LW +: LW]),
      .b    (op_b[i*LW +: LW]),
      .prod (s1_prod[i])
    );
    pmul_half_sel #(.LW(LW)) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (s1_valid),
      .mode (s1_mode),
      .prod (s1_prod[i]),
      .half (res_data[i*LW +: LW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= s1_valid;
  end
endmodule

// File: rtl/pmul16x4_chk.sv
module pmul16x4_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_mode,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        res_valid,
  input logic [63:0] res_data
);
  // Cycles since reset, saturating, so that $past looks only at post-reset values
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic warm;
  assign warm = (age >= 2'd2);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (res_valid == $past(op_valid, 2)));

  a_r6_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_valid && $past(op_mode, 2) == 2'd3) |-> (res_data == 64'd0));

  a_r3_low_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_valid && $past(op_mode, 2) == 2'd0) |->
      (res_data[15:0] == 16'($past(op_a[15:0], 2) * $past(op_b[15:0], 2))));

  a_r5_uns_lane3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_valid && $past(op_mode, 2) == 2'd2) |->
      (res_data[63:48] ==
        16'(({16'd0, $past(op_a[63:48], 2)} * {16'd0, $past(op_b[63:48], 2)}) >> 16)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
endmodule

bind pmul16x4 pmul16x4_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_mode  (op_mode),
  .op_a     (op_a),
  .op_b     (op_b),
  .res_valid(res_valid),
  .res_data (res_data)
);

// File: tb/pmul16x4_tb.sv
module pmul16x4_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_mode = 2'd0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmul16x4 u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data)
  );

  // Reference: integer arithmetic on whole numbers, then shift/mask
  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                           input logic [1:0] m);
    longint sp;
    longint up;
    sp = longint'($signed(a)) * longint'($signed(b));
    up = longint'(a) * longint'(b);
    case (m)
      2'd0: return up[15:0];
      2'd1: return sp[31:16];
      2'd2: return up[31:16];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] m);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16], m);
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input bit lanechk);
    if (lanechk) return "R7";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected pipeline (two stages) and last delivered value
  bit          ev1 = 0, ev2 = 0;
  logic [63:0] ed1 = '0, ed2 = '0;
  string       et1 = "", et2 = "";
  logic [63:0] held = '0;

  // Called on a negedge: check outputs, then drive the next input
  task automatic step(input bit v, input logic [1:0] m, input logic [63:0] a,
                      input logic [63:0] b, input bit lanechk);
    check("R2 valid", {63'd0, res_valid}, {63'd0, ev2});
    if (ev2) begin
      check(et2, res_data, ed2);
      held = ed2;
    end else begin
      check("R8 hold", res_data, held);
    end
    ev2 = ev1; ed2 = ed1; et2 = et1;
    ev1 = v;
    ed1 = ref_word(a, b, m);
    et1 = tag_of(m, lanechk);
    op_valid = v; op_mode = m; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    check("R1 reset data", res_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {63'd0, res_valid}, 64'd0);
    check("R1 data after release", res_data, 64'd0);

    // Directed corners (R4, R5, R7)
    step(1, 2'd1, 64'h8000_FFFF_8000_1234, 64'h7FFF_FFFF_8000_0003, 1'b0);
    step(1, 2'd2, 64'hFFFF_8000_0001_FFFF, 64'hFFFF_8000_0001_0002, 1'b0);
    step(1, 2'd0, 64'hFFFF_8000_0100_00FF, 64'hFFFF_0002_0100_00FF, 1'b0);
    step(1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // R7: only one lane nonzero, neighbours must stay zero
    for (int ln = 0; ln < 4; ln++)
      for (int m = 0; m < 3; m++)
        step(1, 2'(m), 64'hFFFF << (16*ln), 64'h8001 << (16*ln), 1'b1);
    // R8: idle after zero-mode result and after a normal result
    step(1, 2'd1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0);
    step(1, 2'd3, rnd64(), rnd64(), 1'b0);
    step(0, 2'd1, rnd64(), rnd64(), 1'b0);
    step(0, 2'd2, rnd64(), rnd64(), 1'b0);
    step(0, 2'd0, rnd64(), rnd64(), 1'b0);

    // Random stream with gaps
    for (int n = 0; n < 2000; n++)
      step(($urandom() % 4) != 0, 2'($urandom()), rnd64(), rnd64(), 1'b0);
    // drain
    step(0, 2'd0, '0, '0, 1'b0);
    step(0, 2'd0, '0, '0, 1'b0);
    step(0, 2'd0, '0, '0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule